// File: doc/BRIEF.md
# Dual-Channel PWM Action Qualifier with Continuous Override

This block is the output stage of a two-channel PWM generator. Each clock cycle it receives four single-cycle event strobes from the time base and comparators: counter reached zero, counter reached period, an up-count match on comparator A, and an up-count match on comparator B. Each channel has its own action register that tells the output what to do on each event: leave it, drive it low, drive it high or invert it. When several events arrive together, only the highest-ranked one counts.

A continuous software override sits on top of the event actions. Software writes a staged override value, and a selectable reload policy decides when that value becomes active. The policy can be the zero event, the period event, either of them, or every cycle. While an active override forces a channel low or high, that channel holds the forced level and ignores its events.

Each channel's output level is held by a two-state machine with the states LVL_LOW and LVL_HIGH. The named transitions are RISE (LVL_LOW to LVL_HIGH), FALL (LVL_HIGH to LVL_LOW) and HOLD (the state is unchanged). A forced level overrides the event action when the next state is chosen. Registers are written through a single write strobe, a 2-bit select and a 16-bit data word.

Top module: `aq_dual_action`

## Requirements
- R1: After reset both outputs are low, both action registers and the reload mode are zero, and both the staged and the active override fields hold 11 (no override).
- R2: An action field value of 00 leaves the output unchanged, 01 drives it low, 10 drives it high and 11 inverts it. The new level appears at the same clock edge that samples the event.
- R3: In each action register the zero-event action is in bits 1:0, the period action in bits 3:2, the compare-A action in bits 5:4 and the compare-B action in bits 9:8. All other bits have no effect on the output.
- R4: When events coincide, only the highest-ranked event present selects the action, even if that action is 00. The ranking is compare B, then compare A, then period, then zero.
- R5: In the override register, bits 1:0 control channel A and bits 3:2 control channel B. In each field, 01 forces low, 10 forces high, and 11 or 00 means no override.
- R6: While a channel's active override is 01 or 10, the channel's output stays at the forced level and its event actions have no effect.
- R7: The reload mode is held in bits 7:6 of the mode register. The staged override is copied to the active override on a zero event (mode 00), on a period event (01), on either event (10) or on every cycle (11). At other times a staged write has no effect on the outputs.
- R8: In mode 11, an override written at clock edge N becomes active at edge N+1, and the output shows the forced level after edge N+2.
- R9: Each channel uses only its own action register. Channel B's events and actions never move channel A, and channel A's never move channel B.
- R10: Select 0 writes channel A's action register, 1 writes channel B's, 2 writes the mode register and 3 writes the staged override. A write takes effect for events sampled from the next clock edge onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_zero | input | 1 | Counter-at-zero event strobe |
| ev_period | input | 1 | Counter-at-period event strobe |
| ev_cmpa_up | input | 1 | Compare-A match on up count |
| ev_cmpb_up | input | 1 | Compare-B match on up count |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 act A, 1 act B, 2 mode, 3 override) |
| cfg_wdata | input | 16 | Register write data |
| pwm_a | output | 1 | Channel A output |
| pwm_b | output | 1 | Channel B output |

## Verification
An event action shows on the outputs right after the clock edge that samples the event, because only one state register lies in that path. A register write affects only events sampled at later edges. An override in mode 11 needs two further edges after its write edge: one to load the active copy and one to move the output. The bench drives inputs just after a rising edge and samples 1 ns after the next edge. It advances a reference model once per edge, and each directed expectation is stated for the exact edge count given above, including the intermediate edges where the output must not yet have moved.

// File: rtl/aq_pkg.sv
package aq_pkg;

    localparam int AQ_DATA_W = 16;
    localparam int AQ_CH_N   = 2;
    localparam int AQ_FLD_W  = 2;

    // Action register field positions
    localparam int AQ_ZRO_LSB = 0;
    localparam int AQ_PRD_LSB = 2;
    localparam int AQ_CA_LSB  = 4;
    localparam int AQ_CB_LSB  = 8;

    // Mode register: reload policy field
    localparam int AQ_MODE_LSB = 6;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } aq_act_e;

    typedef enum logic [1:0] {
        RLD_ZERO  = 2'b00,
        RLD_PRD   = 2'b01,
        RLD_EITHER = 2'b10,
        RLD_EVERY = 2'b11
    } aq_rld_e;

    localparam logic [1:0] FRC_LOW  = 2'b01;
    localparam logic [1:0] FRC_HIGH = 2'b10;
    localparam logic [1:0] FRC_OFF  = 2'b11;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } aq_lvl_e;

    typedef struct packed {
        logic cmpb;
        logic cmpa;
        logic prd;
        logic zro;
    } aq_evt_t;

endpackage

// File: rtl/aq_event_arbiter.sv
module aq_event_arbiter
    import aq_pkg::*;
#(
    parameter int DATA_W = AQ_DATA_W
) (
    input  aq_evt_t           evt,
    input  logic [DATA_W-1:0] act_reg,
    output aq_act_e           act
);

    always_comb begin
        if (evt.cmpb) begin
            act = aq_act_e'(act_reg[AQ_CB_LSB +: AQ_FLD_W]);
        end else if (evt.cmpa) begin
            act = aq_act_e'(act_reg[AQ_CA_LSB +: AQ_FLD_W]);
        end else if (evt.prd) begin
            act = aq_act_e'(act_reg[AQ_PRD_LSB +: AQ_FLD_W]);
        end else if (evt.zro) begin
            act = aq_act_e'(act_reg[AQ_ZRO_LSB +: AQ_FLD_W]);
        end else begin
            act = ACT_NONE;
        end
    end

endmodule

// File: rtl/aq_chan_fsm.sv
module aq_chan_fsm
    import aq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  aq_act_e    act,
    input  logic [1:0] frc,
    output logic       pwm
);

    aq_lvl_e state_q;
    aq_lvl_e state_d;

    // Next-state selection: a forced level wins over the event action
    always_comb begin
        state_d = state_q;
        if (frc == FRC_LOW) begin
            state_d = LVL_LOW;
        end else if (frc == FRC_HIGH) begin
            state_d = LVL_HIGH;
        end else begin
            unique case (state_q)
                LVL_LOW: begin
                    if (act == ACT_HIGH || act == ACT_TOGGLE) begin
                        state_d = LVL_HIGH;            // RISE
                    end
                end
                LVL_HIGH: begin
                    if (act == ACT_LOW || act == ACT_TOGGLE) begin
                        state_d = LVL_LOW;             // FALL
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LVL_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        pwm = (state_q == LVL_HIGH);
    end

endmodule

// File: rtl/aq_force_reload.sv
module aq_force_reload
    import aq_pkg::*;
#(
    parameter int DATA_W = AQ_DATA_W,
    parameter int CH_N   = AQ_CH_N
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  aq_evt_t                evt,
    input  logic                   wr_mode,
    input  logic                   wr_frc,
    input  logic [DATA_W-1:0]      wdata,
    output aq_rld_e                mode,
    output logic [2*CH_N-1:0]      frc_active
);

    localparam int FRC_W = 2 * CH_N;

    logic [FRC_W-1:0] frc_shadow;
    logic             load;

    always_comb begin
        unique case (mode)
            RLD_ZERO:   load = evt.zro;
            RLD_PRD:    load = evt.prd;
            RLD_EITHER: load = evt.zro | evt.prd;
            RLD_EVERY:  load = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode       <= RLD_ZERO;
            frc_shadow <= {CH_N{FRC_OFF}};
            frc_active <= {CH_N{FRC_OFF}};
        end else begin
            if (wr_mode) begin
                mode <= aq_rld_e'(wdata[AQ_MODE_LSB +: AQ_FLD_W]);
            end
            if (wr_frc) begin
                frc_shadow <= wdata[FRC_W-1:0];
            end
            if (load) begin
                frc_active <= frc_shadow;
            end
        end
    end

endmodule

// File: rtl/aq_dual_action.sv
module aq_dual_action
    import aq_pkg::*;
#(
    parameter int DATA_W = AQ_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_zero,
    input  logic              ev_period,
    input  logic              ev_cmpa_up,
    input  logic              ev_cmpb_up,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              pwm_a,
    output logic              pwm_b
);

    localparam int CH_N  = AQ_CH_N;
    localparam int FRC_W = 2 * CH_N;

    aq_evt_t            evt;
    logic [DATA_W-1:0]  act_q [CH_N];
    aq_rld_e            reload_mode;
    logic [FRC_W-1:0]   frc_active;
    logic [CH_N-1:0]    pwm_v;

    always_comb begin
        evt.cmpb = ev_cmpb_up;
        evt.cmpa = ev_cmpa_up;
        evt.prd  = ev_period;
        evt.zro  = ev_zero;
    end

    aq_force_reload #(
        .DATA_W (DATA_W),
        .CH_N   (CH_N)
    ) frc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .wr_mode    (cfg_we && cfg_sel == 2'd2),
        .wr_frc     (cfg_we && cfg_sel == 2'd3),
        .wdata      (cfg_wdata),
        .mode       (reload_mode),
        .frc_active (frc_active)
    );

    for (genvar c = 0; c < CH_N; c++) begin : g_chan
        aq_act_e act_sel;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_q[c] <= '0;
            end else if (cfg_we && cfg_sel == 2'(c)) begin
                act_q[c] <= cfg_wdata;
            end
        end

        aq_event_arbiter #(
            .DATA_W (DATA_W)
        ) arb_i (
            .evt     (evt),
            .act_reg (act_q[c]),
            .act     (act_sel)
        );

        aq_chan_fsm fsm_i (
            .clk   (clk),
            .rst_n (rst_n),
            .act   (act_sel),
            .frc   (frc_active[2*c +: 2]),
            .pwm   (pwm_v[c])
        );
    end

    assign pwm_a = pwm_v[0];
    assign pwm_b = pwm_v[1];

endmodule

// File: rtl/aq_dual_action_chk.sv
module aq_dual_action_chk
    import aq_pkg::*;
#(
    parameter int DATA_W = AQ_DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_zero,
    input logic              ev_period,
    input logic              ev_cmpa_up,
    input logic              ev_cmpb_up,
    input logic              pwm_a,
    input logic              pwm_b,
    input logic [3:0]        frc_act,
    input logic [1:0]        rld_mode,
    input logic [DATA_W-1:0] act_b_reg
);

    logic any_evt;
    logic a_free;
    logic b_free;

    assign any_evt = ev_zero | ev_period | ev_cmpa_up | ev_cmpb_up;
    assign a_free  = (frc_act[1:0] == 2'b11) || (frc_act[1:0] == 2'b00);
    assign b_free  = (frc_act[3:2] == 2'b11) || (frc_act[3:2] == 2'b00);

    AST_FORCE_LOW_A: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_act[1:0] == 2'b01) |=> !pwm_a); // R6

    AST_FORCE_HIGH_B: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_act[3:2] == 2'b10) |=> pwm_b); // R5

    AST_QUIET_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_evt && a_free) |=> $stable(pwm_a)); // R2

    AST_RELOAD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rld_mode != 2'b11 && !ev_zero && !ev_period) |=> $stable(frc_act)); // R7

    AST_CMPB_TOGGLE_B: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_cmpb_up && b_free && act_b_reg[9:8] == 2'b11) |=> (pwm_b != $past(pwm_b))); // R4

endmodule

bind aq_dual_action aq_dual_action_chk #(.DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_zero    (ev_zero),
    .ev_period  (ev_period),
    .ev_cmpa_up (ev_cmpa_up),
    .ev_cmpb_up (ev_cmpb_up),
    .pwm_a      (pwm_a),
    .pwm_b      (pwm_b),
    .frc_act    (frc_active),
    .rld_mode   (reload_mode),
    .act_b_reg  (act_q[1])
);

// File: tb/aq_dual_action_tb_top.sv
`timescale 1ns/1ps
module aq_dual_action_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_zero = 1'b0, ev_period = 1'b0, ev_cmpa_up = 1'b0, ev_cmpb_up = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        pwm_a, pwm_b;

    int checks = 0;
    int fails  = 0;

    // reference model state
    logic [15:0] m_act [2];
    logic [1:0]  m_mode;
    logic [3:0]  m_shadow;
    logic [3:0]  m_active;
    logic        m_out [2];

    always #5 clk = ~clk;

    aq_dual_action dut_i (
        .clk(clk), .rst_n(rst_n),
        .ev_zero(ev_zero), .ev_period(ev_period),
        .ev_cmpa_up(ev_cmpa_up), .ev_cmpb_up(ev_cmpb_up),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic next_level(input logic cur, input logic [1:0] frc,
                                        input logic [15:0] ar, input logic [3:0] ev);
        logic [1:0] a;
        if (frc == 2'b01) return 1'b0;
        if (frc == 2'b10) return 1'b1;
        // ev = {cmpb, cmpa, prd, zro}
        if (ev[3])      a = ar[9:8];
        else if (ev[2]) a = ar[5:4];
        else if (ev[1]) a = ar[3:2];
        else if (ev[0]) a = ar[1:0];
        else            a = 2'b00;
        case (a)
            2'b01:   return 1'b0;
            2'b10:   return 1'b1;
            2'b11:   return ~cur;
            default: return cur;
        endcase
    endfunction

    function automatic logic reload_now(input logic [1:0] md, input logic [3:0] ev);
        case (md)
            2'b00:   return ev[0];
            2'b01:   return ev[1];
            2'b10:   return ev[0] | ev[1];
            default: return 1'b1;
        endcase
    endfunction

    task automatic model_reset();
        m_act[0] = '0; m_act[1] = '0;
        m_mode = 2'b00; m_shadow = 4'hF; m_active = 4'hF;
        m_out[0] = 1'b0; m_out[1] = 1'b0;
    endtask

    // One cycle: drive, clock, advance model, compare (R2/R4/R6/R7 model check)
    task automatic cyc(input logic [3:0] ev, input logic we, input logic [1:0] sel,
                       input logic [15:0] wd);
        logic n0, n1;
        ev_zero = ev[0]; ev_period = ev[1]; ev_cmpa_up = ev[2]; ev_cmpb_up = ev[3];
        cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
        @(posedge clk);
        #1;
        n0 = next_level(m_out[0], m_active[1:0], m_act[0], ev);
        n1 = next_level(m_out[1], m_active[3:2], m_act[1], ev);
        if (reload_now(m_mode, ev)) m_active = m_shadow;
        if (we) begin
            case (sel)
                2'd0: m_act[0] = wd;
                2'd1: m_act[1] = wd;
                2'd2: m_mode = wd[7:6];
                default: m_shadow = wd[3:0];
            endcase
        end
        m_out[0] = n0; m_out[1] = n1;
        ev_zero = 0; ev_period = 0; ev_cmpa_up = 0; ev_cmpb_up = 0; cfg_we = 0;
        check("model R2 R4 R6 R7 R10 chA", pwm_a, m_out[0]);
        check("model R2 R4 R6 R7 R9 chB", pwm_b, m_out[1]);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] wd);
        cyc(4'b0000, 1'b1, sel, wd);
    endtask

    localparam logic [3:0] EZ = 4'b0001, EP = 4'b0010, EA = 4'b0100, EB = 4'b1000;

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        check("R1 pwm_a reset", pwm_a, 1'b0);
        check("R1 pwm_b reset", pwm_b, 1'b0);

        // R3 / R10: zero field drives high
        wr(2'd0, 16'h0002);
        cyc(EZ, 0, 0, 0);
        check("R3 zero field high", pwm_a, 1'b1);
        // R3: junk in unused bits, zero field low, period field 00
        wr(2'd0, 16'hFCC1);
        cyc(EZ, 0, 0, 0);
        check("R3 zero field low with unused bits set", pwm_a, 1'b0);
        cyc(EP, 0, 0, 0);
        check("R2 period field 00 no change", pwm_a, 1'b0);

        // R2 toggle on compare A
        wr(2'd0, 16'h0030);
        cyc(EA, 0, 0, 0);
        check("R2 toggle to high", pwm_a, 1'b1);
        cyc(EA, 0, 0, 0);
        check("R2 toggle to low", pwm_a, 1'b0);

        // R4 priority
        wr(2'd0, 16'h0122);
        cyc(EZ, 0, 0, 0);
        check("R4 setup zero high", pwm_a, 1'b1);
        cyc(EA | EB, 0, 0, 0);
        check("R4 cmpB beats cmpA", pwm_a, 1'b0);
        cyc(EA | EZ, 0, 0, 0);
        check("R4 cmpA applied", pwm_a, 1'b1);
        wr(2'd0, 16'h0032);
        cyc(EA | EB, 0, 0, 0);
        check("R4 cmpB with 00 masks cmpA toggle", pwm_a, 1'b1);

        // R9 channel B independent
        wr(2'd1, 16'h0008);
        cyc(EP, 0, 0, 0);
        check("R9 chB period high", pwm_b, 1'b1);
        check("R9 chA untouched", pwm_a, 1'b1);

        // R8 / R5 / R6 immediate override of A low, B none
        wr(2'd2, 16'h00C0);
        wr(2'd3, 16'h000D);
        check("R8 not yet after write edge", pwm_a, 1'b1);
        cyc(4'b0000, 0, 0, 0);
        check("R8 not yet after load edge", pwm_a, 1'b1);
        cyc(4'b0000, 0, 0, 0);
        check("R8 forced low after second edge", pwm_a, 1'b0);
        cyc(EA, 0, 0, 0);
        check("R6 toggle ignored while forced", pwm_a, 1'b0);
        check("R5 chB field 11 no override", pwm_b, 1'b1);

        // R7 mode 00: release only on zero event
        wr(2'd2, 16'h0000);
        wr(2'd3, 16'h000F);
        cyc(4'b0000, 0, 0, 0);
        cyc(EP, 0, 0, 0);
        cyc(EA, 0, 0, 0);
        check("R7 mode 00 period does not reload", pwm_a, 1'b0);
        cyc(EZ, 0, 0, 0);
        check("R7 reload edge still forced", pwm_a, 1'b0);
        cyc(EA, 0, 0, 0);
        check("R7 released after zero reload", pwm_a, 1'b1);

        // R7 mode 01: load only on period
        wr(2'd2, 16'h0040);
        wr(2'd3, 16'h0007);
        cyc(EZ, 0, 0, 0);
        cyc(4'b0000, 0, 0, 0);
        check("R7 mode 01 zero does not reload", pwm_b, 1'b1);
        cyc(EP, 0, 0, 0);
        check("R7 load edge chB still high", pwm_b, 1'b1);
        cyc(4'b0000, 0, 0, 0);
        check("R7 chB forced low after period load", pwm_b, 1'b0);

        // R5 field 00 means no override
        wr(2'd2, 16'h00C0);
        wr(2'd3, 16'h0000);
        cyc(4'b0000, 0, 0, 0);
        cyc(EP, 0, 0, 0);
        check("R5 field 00 releases chB", pwm_b, 1'b1);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] ev;
            logic       we;
            ev[0] = ($urandom % 4) == 0;
            ev[1] = ($urandom % 4) == 0;
            ev[2] = ($urandom % 4) == 0;
            ev[3] = ($urandom % 5) == 0;
            we    = ($urandom % 6) == 0;
            cyc(ev, we, 2'($urandom % 4), 16'($urandom));
        end

        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule